// File: doc/BRIEF.md
# Dual-Channel Reset and Restart Controller

This block derives every reset of a two-channel line terminator from two sources. Each channel has an active-low hardware reset pin. Software can also write single-cycle control strobes that carry reset and restart bits for individual functional blocks. For each channel the block drives two clear signals into four register domains: the line interface, the framer, the data-link receiver and the data-link transmitter. A register-clear puts a domain's parameter and control registers back to their defaults. A state-clear reinitialises only the domain's operating logic and leaves its configuration in place. A global clear for the shared registers is asserted only while every channel is held in hardware reset.

A hardware reset takes effect on the channel at once. It is released through a two-stage synchronizer in the core clock domain. A software bit does not stay set. It starts a self-timed pulse of a fixed length, then the pulse ends on its own. A rate-select pin is captured per channel while that channel is in reset, and the value held at release chooses which set of line-interface defaults the channel loads.

Top module: `rrc_top`

## Requirements
- R1: While `hw_rst_n[c]` is 0, all four bits of channel c's `reg_clr` and `st_clr` read 1. This takes effect without waiting for a clock edge.
- R2: After `hw_rst_n[c]` returns to 1, the channel's clears stay asserted through the first rising edge and drop at the second rising edge. They then stay low for as long as the pin stays high.
- R3: A reset, restart or software write on one channel leaves the other channel's outputs unchanged.
- R4: `glob_clr` is 1 only while the synchronized resets of both channels are asserted together. It drops at the same edge as the earlier of the two releases.
- R5: While channel c is in reset, `dflt_t1[c]` follows `rate_sel_t1` from the previous edge. After release it holds the value it had at release. A 1 means T1-rate defaults with short-span equalization, and a 0 means E1-rate defaults with the first cable option.
- R6: A write with `sw_sel` = 0 (line control) and data bit 5 set drives line `st_clr` (domain bit 0) high for exactly 4 cycles, starting the cycle after the write. Line `reg_clr` stays 0 throughout.
- R7: A write with `sw_sel` = 1 (framer control) and data bit 0 set drives framer `reg_clr` and `st_clr` (domain bit 1) high for exactly 4 cycles.
- R8: A write with `sw_sel` = 1 and data bit 1 set drives framer `st_clr` high for 4 cycles. Framer `reg_clr` stays 0.
- R9: A write with `sw_sel` = 2 and data bit 1 set pulses the data-link receiver clears (domain bit 2) for 4 cycles. A write with `sw_sel` = 3 and data bit 5 set does the same for the data-link transmitter clears (domain bit 3).
- R10: A write with none of its control bits set starts no pulse. A write sampled while the channel's synchronized reset is still asserted is discarded.
- R11: Whenever a domain's `reg_clr` is 1, its `st_clr` is also 1.
- R12: Writing the same bit again while its pulse is active restarts the 4-cycle count from the new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| hw_rst_n | input | 2 | Per-channel hardware reset, active low; bit c is channel c |
| rate_sel_t1 | input | 1 | Default-set select: 1 = T1 short-span, 0 = E1 first cable option |
| sw_wr | input | 2 | Per-channel control write strobe, one cycle |
| sw_sel | input | 4 | Per-channel target register, 2 bits each: 0 line, 1 framer, 2 data-link rx, 3 data-link tx |
| sw_data | input | 16 | Per-channel write data, 8 bits each |
| reg_clr | output | 8 | Register-clear, 4 domain bits per channel (bit 4c+d) |
| st_clr | output | 8 | State-clear, same layout as reg_clr |
| glob_clr | output | 1 | Clear of the shared registers |
| dflt_t1 | output | 2 | Captured default-set select per channel |

## Verification
The bench samples both edges of the release window and the cycle after it. A synchronizer that is one stage short would open the clears one cycle early, and one that is a stage long would hold them a cycle late. It staggers the two channel releases to show that the global clear follows the first release and is not OR-ed across channels. It writes each control bit with its neighbours set and the bit itself clear, and it restarts a pulse while one is running. A decoder tied to the wrong bit would start a pulse on a write that should do nothing or miss one that should start it, and a counter that does not reload would end the retriggered pulse early. A write placed in the last cycle of a reset must not start a pulse; a design that lets the write win over the reset would emit a clear right after release.

// File: rtl/rrc_pkg.sv
// Shared encodings of the reset/restart controller: domain bit order,
// control-register select codes, control bit positions, pulse sources.
// Assumes every channel uses the same layout.
package rrc_pkg;
    localparam int DOM_N    = 4;
    localparam int DOM_LINE = 0;
    localparam int DOM_FRM  = 1;
    localparam int DOM_DLRX = 2;
    localparam int DOM_DLTX = 3;

    typedef enum logic [1:0] {
        SEL_LINE = 2'd0,
        SEL_FRM  = 2'd1,
        SEL_DLRX = 2'd2,
        SEL_DLTX = 2'd3
    } sel_e;

    localparam int SEL_W  = 2;
    localparam int DATA_W = 8;

    localparam int BIT_LINE_RESTART = 5;
    localparam int BIT_FRM_RESET    = 0;
    localparam int BIT_FRM_RESTART  = 1;
    localparam int BIT_DLRX_RESET   = 1;
    localparam int BIT_DLTX_RESET   = 5;

    localparam int SRC_N           = 5;
    localparam int SRC_LINE_RESTART = 0;
    localparam int SRC_FRM_RESET    = 1;
    localparam int SRC_FRM_RESTART  = 2;
    localparam int SRC_DLRX_RESET   = 3;
    localparam int SRC_DLTX_RESET   = 4;
endpackage

// File: rtl/rrc_sync.sv
// Reset synchronizer: asserts in_rst as soon as arst_n falls and releases
// it STAGES rising edges after arst_n returns high.
// Assumes arst_n is glitch-free; STAGES >= 2.
module rrc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic in_rst
);
    logic [STAGES-1:0] shreg;

    // Shift ones in after release, clear at once on assertion.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[STAGES-2:0], 1'b1};
        end
    end

    assign in_rst = ~shreg[STAGES-1];

    // Once released, the channel stays out of reset while the pin is high.
    assert_stays_released_R2: assert property (@(posedge clk) disable iff (!arst_n)
        !in_rst |=> !in_rst);
endmodule

// File: rtl/rrc_pulse.sv
// Self-timed pulse: a start strobe makes active high for LEN cycles from
// the next cycle; a new start reloads the count. Assumes LEN >= 1 and a
// synchronous active-low rst_n that clears any pending pulse.
module rrc_pulse #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt;

    // Load on start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(LEN);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign active = (cnt != '0);

    // A start is visible on the output the following cycle.
    assert_start_fires_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> active);
    // With no start, an idle output stays idle.
    assert_no_spurious_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !start) |=> !active);
endmodule

// File: rtl/rrc_chan.sv
// One channel: synchronizes its hardware reset, decodes software control
// writes into five pulse sources and merges them into per-domain register
// and state clears. Also captures the default-set select during reset.
// Assumes sw_wr is a single-cycle strobe in the clk domain.
module rrc_chan
    import rrc_pkg::*;
#(
    parameter int PULSE_LEN   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              hw_rst_n,
    input  logic              rate_sel_t1,
    input  logic              sw_wr,
    input  logic [SEL_W-1:0]  sw_sel,
    input  logic [DATA_W-1:0] sw_data,
    output logic [DOM_N-1:0]  reg_clr,
    output logic [DOM_N-1:0]  st_clr,
    output logic              in_rst,
    output logic              dflt_t1
);
    logic [SRC_N-1:0] start;
    logic [SRC_N-1:0] act;

    rrc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .arst_n (hw_rst_n),
        .in_rst (in_rst)
    );

    // Map the written register and its bits onto pulse sources.
    always_comb begin
        start = '0;
        if (sw_wr) begin
            case (sel_e'(sw_sel))
                SEL_LINE: start[SRC_LINE_RESTART] = sw_data[BIT_LINE_RESTART];
                SEL_FRM: begin
                    start[SRC_FRM_RESET]   = sw_data[BIT_FRM_RESET];
                    start[SRC_FRM_RESTART] = sw_data[BIT_FRM_RESTART];
                end
                SEL_DLRX: start[SRC_DLRX_RESET] = sw_data[BIT_DLRX_RESET];
                SEL_DLTX: start[SRC_DLTX_RESET] = sw_data[BIT_DLTX_RESET];
                default:  start = '0;
            endcase
        end
    end

    for (genvar s = 0; s < SRC_N; s++) begin : g_src
        rrc_pulse #(.LEN(PULSE_LEN)) u_pulse (
            .clk    (clk),
            .rst_n  (~in_rst),
            .start  (start[s]),
            .active (act[s])
        );
    end

    // Merge hardware reset and soft pulses into domain clears.
    always_comb begin
        reg_clr[DOM_LINE] = in_rst;
        st_clr[DOM_LINE]  = in_rst | act[SRC_LINE_RESTART];
        reg_clr[DOM_FRM]  = in_rst | act[SRC_FRM_RESET];
        st_clr[DOM_FRM]   = in_rst | act[SRC_FRM_RESET] | act[SRC_FRM_RESTART];
        reg_clr[DOM_DLRX] = in_rst | act[SRC_DLRX_RESET];
        st_clr[DOM_DLRX]  = in_rst | act[SRC_DLRX_RESET];
        reg_clr[DOM_DLTX] = in_rst | act[SRC_DLTX_RESET];
        st_clr[DOM_DLTX]  = in_rst | act[SRC_DLTX_RESET];
    end

    // Track the rate select while in reset; hold it once released.
    always_ff @(posedge clk) begin
        if (in_rst) begin
            dflt_t1 <= rate_sel_t1;
        end
    end

    // Outside reset the captured default set never moves.
    assert_dflt_held_R5: assert property (@(posedge clk) disable iff (in_rst)
        !in_rst |=> $stable(dflt_t1));
    // A framer restart write clears state but keeps the framer registers.
    assert_restart_keeps_regs_R8: assert property (@(posedge clk) disable iff (in_rst)
        (sw_wr && sw_sel == SEL_FRM && sw_data[BIT_FRM_RESTART]
         && !sw_data[BIT_FRM_RESET] && !reg_clr[DOM_FRM])
        |=> (st_clr[DOM_FRM] && !reg_clr[DOM_FRM]));
endmodule

// File: rtl/rrc_top.sv
// Reset and restart controller for NCH line-terminator channels: one
// rrc_chan per channel plus the shared-register clear, which is asserted
// only while every channel is in synchronized reset.
// Assumes all inputs are in the clk domain except hw_rst_n.
module rrc_top
    import rrc_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int PULSE_LEN   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic [NCH-1:0]        hw_rst_n,
    input  logic                  rate_sel_t1,
    input  logic [NCH-1:0]        sw_wr,
    input  logic [NCH*SEL_W-1:0]  sw_sel,
    input  logic [NCH*DATA_W-1:0] sw_data,
    output logic [NCH*DOM_N-1:0]  reg_clr,
    output logic [NCH*DOM_N-1:0]  st_clr,
    output logic                  glob_clr,
    output logic [NCH-1:0]        dflt_t1
);
    logic [NCH-1:0] ch_in_rst;
    logic [NCH-1:0] line_regclr;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        rrc_chan #(
            .PULSE_LEN   (PULSE_LEN),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_chan (
            .clk         (clk),
            .hw_rst_n    (hw_rst_n[c]),
            .rate_sel_t1 (rate_sel_t1),
            .sw_wr       (sw_wr[c]),
            .sw_sel      (sw_sel[c*SEL_W +: SEL_W]),
            .sw_data     (sw_data[c*DATA_W +: DATA_W]),
            .reg_clr     (reg_clr[c*DOM_N +: DOM_N]),
            .st_clr      (st_clr[c*DOM_N +: DOM_N]),
            .in_rst      (ch_in_rst[c]),
            .dflt_t1     (dflt_t1[c])
        );
        assign line_regclr[c] = reg_clr[c*DOM_N + DOM_LINE];
    end

    assign glob_clr = &ch_in_rst;

    // The shared clear implies every channel's line registers are cleared too.
    assert_glob_needs_all_R4: assert property (@(posedge clk) disable iff (hw_rst_n == '0)
        glob_clr |-> (&line_regclr));
endmodule

// File: tb/sim_rrc_top.sv
// Scoreboard bench: driver steps push expected per-channel output items,
// a monitor pops and compares them at the falling edge of their cycle.
module sim_rrc_top;
    logic        clk = 1'b0;
    logic [1:0]  hw_rst_n = 2'b00;
    logic        rate_sel_t1 = 1'b1;
    logic [1:0]  sw_wr = 2'b00;
    logic [3:0]  sw_sel = '0;
    logic [15:0] sw_data = '0;
    logic [7:0]  reg_clr;
    logic [7:0]  st_clr;
    logic        glob_clr;
    logic [1:0]  dflt_t1;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    typedef struct {
        int         at;
        int         ch;
        logic [3:0] r;
        logic [3:0] s;
        logic       g;
        logic       d;
        string      tag;
    } exp_t;

    exp_t sbq[$];

    rrc_top u0 (
        .clk         (clk),
        .hw_rst_n    (hw_rst_n),
        .rate_sel_t1 (rate_sel_t1),
        .sw_wr       (sw_wr),
        .sw_sel      (sw_sel),
        .sw_data     (sw_data),
        .reg_clr     (reg_clr),
        .st_clr      (st_clr),
        .glob_clr    (glob_clr),
        .dflt_t1     (dflt_t1)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc = cyc + 1;

    task automatic expect_at(int at, int ch, logic [3:0] r, logic [3:0] s,
                             logic g, logic d, string tag);
        exp_t e;
        e.at = at; e.ch = ch; e.r = r; e.s = s; e.g = g; e.d = d; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(int ch, logic [1:0] sel, logic [7:0] d);
        sw_wr[ch] = 1'b1;
        sw_sel[ch*2 +: 2] = sel;
        sw_data[ch*8 +: 8] = d;
        tick(1);
        sw_wr[ch] = 1'b0;
    endtask

    // Monitor: compare every item due this cycle; stale items are failures.
    always @(negedge clk) begin
        int i;
        i = 0;
        while (i < sbq.size()) begin
            if (sbq[i].at == cyc) begin
                checks++;
                if (reg_clr[sbq[i].ch*4 +: 4] !== sbq[i].r || st_clr[sbq[i].ch*4 +: 4] !== sbq[i].s
                    || glob_clr !== sbq[i].g || dflt_t1[sbq[i].ch] !== sbq[i].d) begin
                    errors++;
                    $display("FAIL %s ch%0d cyc%0d: reg=%h st=%h glob=%b dflt=%b expected reg=%h st=%h glob=%b dflt=%b",
                             sbq[i].tag, sbq[i].ch, cyc, reg_clr[sbq[i].ch*4 +: 4],
                             st_clr[sbq[i].ch*4 +: 4], glob_clr, dflt_t1[sbq[i].ch],
                             sbq[i].r, sbq[i].s, sbq[i].g, sbq[i].d);
                end
                sbq.delete(i);
            end else if (sbq[i].at < cyc) begin
                checks++;
                errors++;
                $display("FAIL %s ch%0d: item for cycle %0d never sampled, expected reg=%h",
                         sbq[i].tag, sbq[i].ch, sbq[i].at, sbq[i].r);
                sbq.delete(i);
            end else begin
                i++;
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Driver: stimulus steps, each pushing its expected outputs.
    initial begin
        int t;
        int u;
        tick(2);
        t = cyc;
        expect_at(t, 0, 4'hF, 4'hF, 1'b1, 1'b1, "R1 R4 R11 reset state");
        expect_at(t, 1, 4'hF, 4'hF, 1'b1, 1'b1, "R1 R4 reset state");
        hw_rst_n = 2'b11;
        expect_at(t+1, 0, 4'hF, 4'hF, 1'b1, 1'b1, "R2 held through first edge");
        expect_at(t+2, 0, 4'h0, 4'h0, 1'b0, 1'b1, "R2 released at second edge");
        expect_at(t+2, 1, 4'h0, 4'h0, 1'b0, 1'b1, "R5 T1 default captured");
        tick(3);
        rate_sel_t1 = 1'b0;
        expect_at(cyc+2, 0, 4'h0, 4'h0, 1'b0, 1'b1, "R5 default held after release");
        expect_at(cyc+2, 1, 4'h0, 4'h0, 1'b0, 1'b1, "R5 default held after release");
        tick(4);

        t = cyc;
        hw_rst_n[1] = 1'b0;
        expect_at(t, 1, 4'hF, 4'hF, 1'b0, 1'b1, "R1 ch1 alone in reset");
        expect_at(t, 0, 4'h0, 4'h0, 1'b0, 1'b1, "R3 R4 ch0 untouched, no global");
        tick(3);
        t = cyc;
        hw_rst_n[1] = 1'b1;
        expect_at(t+1, 1, 4'hF, 4'hF, 1'b0, 1'b0, "R2 ch1 held one edge");
        expect_at(t+2, 1, 4'h0, 4'h0, 1'b0, 1'b0, "R5 E1 default captured");
        expect_at(t+2, 0, 4'h0, 4'h0, 1'b0, 1'b1, "R3 R5 ch0 default unchanged");
        tick(5);

        t = cyc;
        expect_at(t,   0, 4'h0, 4'h0, 1'b0, 1'b1, "R6 no pulse in write cycle");
        expect_at(t+1, 0, 4'h0, 4'h1, 1'b0, 1'b1, "R6 line restart first cycle");
        expect_at(t+2, 1, 4'h0, 4'h0, 1'b0, 1'b0, "R3 ch1 ignores ch0 write");
        expect_at(t+4, 0, 4'h0, 4'h1, 1'b0, 1'b1, "R6 line restart fourth cycle");
        expect_at(t+5, 0, 4'h0, 4'h0, 1'b0, 1'b1, "R6 line restart ended");
        wr(0, 2'd0, 8'h20);
        tick(6);

        t = cyc;
        expect_at(t+1, 0, 4'h2, 4'h2, 1'b0, 1'b1, "R7 R11 framer reset first cycle");
        expect_at(t+4, 0, 4'h2, 4'h2, 1'b0, 1'b1, "R7 framer reset fourth cycle");
        expect_at(t+5, 0, 4'h0, 4'h0, 1'b0, 1'b1, "R7 framer reset ended");
        wr(0, 2'd1, 8'h01);
        tick(6);

        t = cyc;
        expect_at(t+1, 1, 4'h0, 4'h2, 1'b0, 1'b0, "R8 framer restart keeps regs");
        expect_at(t+4, 1, 4'h0, 4'h2, 1'b0, 1'b0, "R8 framer restart fourth cycle");
        expect_at(t+5, 1, 4'h0, 4'h0, 1'b0, 1'b0, "R8 framer restart ended");
        expect_at(t+2, 0, 4'h0, 4'h0, 1'b0, 1'b1, "R3 ch0 ignores ch1 write");
        wr(1, 2'd1, 8'h02);
        tick(6);

        t = cyc;
        expect_at(t+1, 0, 4'h4, 4'h4, 1'b0, 1'b1, "R9 data-link rx reset");
        expect_at(t+4, 0, 4'h4, 4'h4, 1'b0, 1'b1, "R9 data-link rx fourth cycle");
        expect_at(t+5, 0, 4'h0, 4'h0, 1'b0, 1'b1, "R9 data-link rx ended");
        wr(0, 2'd2, 8'h02);
        tick(6);
        t = cyc;
        expect_at(t+1, 0, 4'h8, 4'h8, 1'b0, 1'b1, "R9 data-link tx reset");
        expect_at(t+4, 0, 4'h8, 4'h8, 1'b0, 1'b1, "R9 data-link tx fourth cycle");
        expect_at(t+5, 0, 4'h0, 4'h0, 1'b0, 1'b1, "R9 data-link tx ended");
        wr(0, 2'd3, 8'h20);
        tick(6);

        t = cyc;
        expect_at(t+1, 0, 4'h0, 4'h0, 1'b0, 1'b1, "R10 line write without bit 5");
        expect_at(t+3, 0, 4'h0, 4'h0, 1'b0, 1'b1, "R10 line write without bit 5");
        wr(0, 2'd0, 8'hDF);
        tick(4);
        t = cyc;
        expect_at(t+1, 0, 4'h0, 4'h0, 1'b0, 1'b1, "R10 framer write without bits 0,1");
        wr(0, 2'd1, 8'hFC);
        tick(4);
        t = cyc;
        expect_at(t+1, 0, 4'h0, 4'h0, 1'b0, 1'b1, "R10 rx write without bit 1");
        wr(0, 2'd2, 8'hFD);
        tick(4);
        t = cyc;
        expect_at(t+1, 0, 4'h0, 4'h0, 1'b0, 1'b1, "R10 tx write without bit 5");
        wr(0, 2'd3, 8'hDF);
        tick(4);

        t = cyc;
        expect_at(t+5, 0, 4'h2, 4'h2, 1'b0, 1'b1, "R12 retriggered pulse still on");
        expect_at(t+6, 0, 4'h2, 4'h2, 1'b0, 1'b1, "R12 retriggered pulse last cycle");
        expect_at(t+7, 0, 4'h0, 4'h0, 1'b0, 1'b1, "R12 retriggered pulse ended");
        wr(0, 2'd1, 8'h01);
        tick(1);
        wr(0, 2'd1, 8'h01);
        tick(7);

        t = cyc;
        hw_rst_n[0] = 1'b0;
        expect_at(t, 0, 4'hF, 4'hF, 1'b0, 1'b1, "R1 R11 ch0 reset");
        tick(2);
        u = cyc;
        hw_rst_n[0] = 1'b1;
        expect_at(u+2, 0, 4'h0, 4'h0, 1'b0, 1'b0, "R10 write in last reset cycle discarded");
        expect_at(u+3, 0, 4'h0, 4'h0, 1'b0, 1'b0, "R10 write in last reset cycle discarded");
        tick(1);
        wr(0, 2'd1, 8'h01);
        tick(5);

        t = cyc;
        hw_rst_n = 2'b00;
        expect_at(t, 0, 4'hF, 4'hF, 1'b1, 1'b0, "R4 both channels low");
        expect_at(t, 1, 4'hF, 4'hF, 1'b1, 1'b0, "R4 both channels low");
        tick(2);
        u = cyc;
        hw_rst_n[0] = 1'b1;
        expect_at(u+1, 0, 4'hF, 4'hF, 1'b1, 1'b0, "R4 global held while ch0 syncs");
        expect_at(u+2, 0, 4'h0, 4'h0, 1'b0, 1'b0, "R4 global drops with first release");
        expect_at(u+2, 1, 4'hF, 4'hF, 1'b0, 1'b0, "R3 R4 ch1 still in reset");
        tick(3);
        hw_rst_n[1] = 1'b1;
        expect_at(cyc+2, 1, 4'h0, 4'h0, 1'b0, 1'b0, "R2 ch1 released");
        tick(5);

        while (sbq.size() != 0) tick(1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule